// File: doc/BRIEF.md
# Search Triplet Sequencer

This block carries out a single decision step of the device-discovery search on a single-wire bus. On a start pulse it asks a bit-level slot engine for two read slots: one returns the current identifier bit of all responding devices, the other its complement. From the pair it picks a branch direction and asks the slot engine for one write slot carrying that direction, so that devices on the other branch drop out. The caller supplies a preferred direction for the case in which both branches are populated.

The step ends with a one-cycle completion pulse and a 3-bit status giving the identifier bit, the complement bit and the direction taken. When both read bits come back as 1, no device answered and the step ends at once, with no write slot, so the caller can restart the search. Slot timing, the 64-step outer loop and discrepancy tracking belong to the caller and to the slot engine.

Top module: `search_triplet_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `slot_rd_req_o` and `slot_wr_req_o` are 0 and `result_o` is 3'b000.
- R2: A step issues, in this order, a read slot for the identifier bit, a read slot for the complement bit, and then (unless aborted) one write slot. Only one request is high at a time, and each request stays high until `slot_ack_i` is seen high with it. The read bit is taken from `slot_rd_bit_i` in the cycle of the acknowledge.
- R3: `result_o` bit 0 is the identifier bit, bit 1 is the complement bit and bit 2 is the direction taken.
- R4: If both read bits are 1, the result is 3'b011 and no write slot is requested in that step.
- R5: If both read bits are 0, the latched preferred direction is written, and the result is 3'b100 when it is 1 and 3'b000 when it is 0.
- R6: If exactly one read bit is 1, the identifier bit is written as the direction, and the result is 3'b101 when the identifier bit is 1 and 3'b010 when it is 0.
- R7: `start_i` is taken only while `busy_o` is 0. A start pulse during a step (including its completion cycle) starts no further slots.
- R8: `pref_dir_i` is sampled in the cycle `start_i` is taken. Later changes to it do not alter the written direction or the result of that step.
- R9: `done_o` is high for exactly one cycle per step, `result_o` is valid in that cycle, and it holds its value until the next step starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one search step when idle |
| pref_dir_i | input | 1 | Direction to take when both branches exist |
| busy_o | output | 1 | Step in progress (also high in the completion cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | RES_W | Status: {direction, complement bit, identifier bit} |
| slot_rd_req_o | output | 1 | Request a read slot |
| slot_wr_req_o | output | 1 | Request a write slot |
| slot_wr_bit_o | output | 1 | Bit value for the requested write slot |
| slot_ack_i | input | 1 | Slot engine reports the current slot finished |
| slot_rd_bit_i | input | 1 | Bit sampled by a read slot, valid with the acknowledge |

## Verification
A wrong state register shows at the slot interface within one acknowledge: a skipped or repeated read slot changes the count of read requests, and a missed abort shows as a write request after a 1/1 read pair. A corrupted captured bit or latched direction shows in the written bit of the same step and in `result_o` at the `done_o` pulse, one cycle after the last acknowledge. A state machine that fails to return to idle shows as `busy_o` staying high or as extra requests in the cycles after `done_o`.

// File: rtl/srch_trip_pkg.sv
package srch_trip_pkg;

   localparam int TRIP_RES_W  = 3;
   localparam int RES_ID_POS  = 0;
   localparam int RES_CMP_POS = 1;
   localparam int RES_DIR_POS = 2;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RD_ID  = 3'd1,
      ST_RD_CMP = 3'd2,
      ST_WR_DIR = 3'd3,
      ST_DONE   = 3'd4
   } trip_state_e;

endpackage

// File: rtl/trip_decide.sv
module trip_decide
   import srch_trip_pkg::*;
#(
   parameter int RES_W = TRIP_RES_W
) (
   input  logic             id_bit_i,
   input  logic             cmp_bit_i,
   input  logic             pref_dir_i,
   output logic             dir_o,
   output logic             abort_o,
   output logic [RES_W-1:0] res_o
);

   logic split;

   always_comb begin
      abort_o = id_bit_i & cmp_bit_i;
      split   = id_bit_i ^ cmp_bit_i;
      if (abort_o)
         dir_o = 1'b0;
      else if (split)
         dir_o = id_bit_i;
      else
         dir_o = pref_dir_i;
      res_o              = '0;
      res_o[RES_ID_POS]  = id_bit_i;
      res_o[RES_CMP_POS] = cmp_bit_i;
      res_o[RES_DIR_POS] = dir_o;
   end

endmodule

// File: rtl/trip_seq_ctrl.sv
module trip_seq_ctrl
   import srch_trip_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic pref_dir_i,
   input  logic slot_ack_i,
   input  logic slot_rd_bit_i,
   input  logic dec_dir_i,
   input  logic dec_abort_i,
   output logic id_q_o,
   output logic cmp_q_o,
   output logic pref_q_o,
   output logic busy_o,
   output logic done_o,
   output logic rd_req_o,
   output logic wr_req_o,
   output logic wr_bit_o
);

   trip_state_e state_q, state_d;
   logic        id_q, cmp_q, pref_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i) state_d = ST_RD_ID;
         ST_RD_ID:  if (slot_ack_i) state_d = ST_RD_CMP;
         ST_RD_CMP: if (slot_ack_i)
                       state_d = (id_q & slot_rd_bit_i) ? ST_DONE : ST_WR_DIR;
         ST_WR_DIR: if (slot_ack_i) state_d = ST_DONE;
         ST_DONE:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         id_q    <= 1'b0;
         cmp_q   <= 1'b0;
         pref_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i)
            pref_q <= pref_dir_i;
         if (state_q == ST_RD_ID && slot_ack_i)
            id_q <= slot_rd_bit_i;
         if (state_q == ST_RD_CMP && slot_ack_i)
            cmp_q <= slot_rd_bit_i;
      end
   end

   assign id_q_o   = id_q;
   assign cmp_q_o  = cmp_q;
   assign pref_q_o = pref_q;
   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = (state_q == ST_DONE);
   assign rd_req_o = (state_q == ST_RD_ID) || (state_q == ST_RD_CMP);
   assign wr_req_o = (state_q == ST_WR_DIR);
   assign wr_bit_o = wr_req_o & dec_dir_i;

   // R2: never two slot requests at once
   a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_o && wr_req_o));

   // R2: a read request is held until acknowledged
   a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !slot_ack_i) |=> rd_req_o);

   // R2: a write request and its bit are held until acknowledged
   a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !slot_ack_i) |=> (wr_req_o && $stable(wr_bit_o)));

   // R4: no write slot after a 1/1 read pair
   a_r4_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> !dec_abort_i);

   // R7: a start taken from idle opens the identifier read
   a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (rd_req_o && busy_o));

   // R7: a step in progress stays busy until completion
   a_r7_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   // R8: latched direction stable throughout a step
   a_r8_pref_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> $stable(pref_q));

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/search_triplet_seq.sv
module search_triplet_seq
   import srch_trip_pkg::*;
#(
   parameter int RES_W = TRIP_RES_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             pref_dir_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [RES_W-1:0] result_o,
   output logic             slot_rd_req_o,
   output logic             slot_wr_req_o,
   output logic             slot_wr_bit_o,
   input  logic             slot_ack_i,
   input  logic             slot_rd_bit_i
);

   generate
      if (RES_W != TRIP_RES_W) begin : g_bad_width
         $error("search_triplet_seq: RES_W must equal TRIP_RES_W");
      end
   endgenerate

   logic             id_q, cmp_q, pref_q;
   logic             dec_dir, dec_abort;
   logic [RES_W-1:0] dec_res;

   trip_seq_ctrl ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .pref_dir_i   (pref_dir_i),
      .slot_ack_i   (slot_ack_i),
      .slot_rd_bit_i(slot_rd_bit_i),
      .dec_dir_i    (dec_dir),
      .dec_abort_i  (dec_abort),
      .id_q_o       (id_q),
      .cmp_q_o      (cmp_q),
      .pref_q_o     (pref_q),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .rd_req_o     (slot_rd_req_o),
      .wr_req_o     (slot_wr_req_o),
      .wr_bit_o     (slot_wr_bit_o)
   );

   trip_decide #(.RES_W(RES_W)) decide_i (
      .id_bit_i  (id_q),
      .cmp_bit_i (cmp_q),
      .pref_dir_i(pref_q),
      .dir_o     (dec_dir),
      .abort_o   (dec_abort),
      .res_o     (dec_res)
   );

   assign result_o = dec_res;

   // R9: status unchanged from the done pulse until the next start
   a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || (!busy_o && !start_i && $past(!busy_o || done_o))) |=>
         (busy_o || $stable(result_o)));

   // R3: an abort status never reports a direction of 1
   a_r3_abort_code: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o[RES_ID_POS] && result_o[RES_CMP_POS]) |->
         !result_o[RES_DIR_POS]);

endmodule

// File: tb/search_triplet_seq_tb_top.sv
module search_triplet_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       pref_dir_i = 1'b0;
   logic       busy_o, done_o;
   logic [2:0] result_o;
   logic       slot_rd_req_o, slot_wr_req_o, slot_wr_bit_o;
   logic       slot_ack_i = 1'b0;
   logic       slot_rd_bit_i = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   // stub slot responder state
   logic resp_id = 1'b0, resp_cmp = 1'b0;
   int   lat = 0;
   int   rd_cnt = 0, wr_cnt = 0;
   logic wr_val = 1'b0;
   int   order_err = 0;

   always #10 clk = ~clk;   // 50 MHz

   search_triplet_seq dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .pref_dir_i   (pref_dir_i),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .result_o     (result_o),
      .slot_rd_req_o(slot_rd_req_o),
      .slot_wr_req_o(slot_wr_req_o),
      .slot_wr_bit_o(slot_wr_bit_o),
      .slot_ack_i   (slot_ack_i),
      .slot_rd_bit_i(slot_rd_bit_i)
   );

   initial begin : responder
      int wait_cnt;
      logic was_req;
      wait_cnt = 0;
      was_req  = 1'b0;
      forever begin
         @(negedge clk);
         if (was_req && !slot_ack_i && !slot_rd_req_o && !slot_wr_req_o)
            order_err++;
         slot_ack_i = 1'b0;
         was_req = slot_rd_req_o | slot_wr_req_o;
         if (slot_rd_req_o && slot_wr_req_o) order_err++;
         if (slot_rd_req_o || slot_wr_req_o) begin
            if (wait_cnt >= lat) begin
               slot_ack_i = 1'b1;
               wait_cnt = 0;
               if (slot_rd_req_o) begin
                  slot_rd_bit_i = (rd_cnt == 0) ? resp_id : resp_cmp;
                  rd_cnt++;
               end else begin
                  if (rd_cnt != 2) order_err++;
                  wr_val = slot_wr_bit_o;
                  wr_cnt++;
               end
            end else begin
               wait_cnt++;
            end
         end else begin
            wait_cnt = 0;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one step; extra_start / flip_pref disturb inputs mid-step
   task automatic run_step(input logic id_b, input logic cmp_b, input logic pref,
                           input int latency, input logic extra_start,
                           input logic flip_pref, input int exp_res,
                           input int exp_wr, input int exp_bit, input string req);
      int guard;
      resp_id = id_b; resp_cmp = cmp_b; lat = latency;
      rd_cnt = 0; wr_cnt = 0; wr_val = 1'b0; order_err = 0;
      @(negedge clk);
      pref_dir_i = pref;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (flip_pref) pref_dir_i = ~pref;
      if (extra_start) start_i = 1'b1;
      guard = 0;
      while (!done_o && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      check({req, " done seen"}, int'(done_o), 1);
      check({req, " result"}, int'(result_o), exp_res);
      check({req, " R2 read slots"}, rd_cnt, 2);
      check({req, " write slots"}, wr_cnt, exp_wr);
      if (exp_wr != 0) check({req, " write bit"}, int'(wr_val), exp_bit);
      check({req, " R2 order/hold"}, order_err, 0);
      // start still high here if extra_start: completion cycle, must be ignored (R7)
      @(negedge clk);
      start_i = 1'b0;
      check({req, " R9 done single"}, int'(done_o), 0);
      check({req, " R9 result held"}, int'(result_o), exp_res);
      repeat (3) @(negedge clk);
      check({req, " R7 idle after"}, int'(busy_o | slot_rd_req_o | slot_wr_req_o), 0);
      check({req, " R9 result still held"}, int'(result_o), exp_res);
   endtask

   task automatic t_reset();
      check("R1 busy", int'(busy_o), 0);
      check("R1 done", int'(done_o), 0);
      check("R1 requests", int'(slot_rd_req_o | slot_wr_req_o), 0);
      check("R1 result", int'(result_o), 0);
   endtask

   task automatic t_abort();
      run_step(1, 1, 1, 0, 0, 0, 3, 0, 0, "R4 abort 1/1 R3");
      run_step(1, 1, 0, 2, 0, 0, 3, 0, 0, "R4 abort slow");
   endtask

   task automatic t_both_zero();
      run_step(0, 0, 1, 0, 0, 0, 4, 1, 1, "R5 zero pref1 R3");
      run_step(0, 0, 0, 3, 0, 0, 0, 1, 0, "R5 zero pref0");
   endtask

   task automatic t_one_set();
      run_step(1, 0, 0, 1, 0, 0, 5, 1, 1, "R6 id1 R3");
      run_step(0, 1, 1, 0, 0, 0, 2, 1, 0, "R6 id0");
   endtask

   task automatic t_pref_latched();
      run_step(0, 0, 1, 2, 0, 1, 4, 1, 1, "R8 pref flip 1->0");
      run_step(0, 0, 0, 2, 0, 1, 0, 1, 0, "R8 pref flip 0->1");
   endtask

   task automatic t_start_busy();
      run_step(1, 0, 1, 1, 1, 0, 5, 1, 1, "R7 start while busy");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_abort();
      t_both_zero();
      t_one_set();
      t_pref_latched();
      t_start_busy();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule